// File: doc/BRIEF.md
# PHY Management Register Front End with PHY Register Model

This block pairs a small word-addressed register front end with a behavioural model of the management register file inside one Ethernet PHY. Software selects a target by writing a PHY address and a register number into a target register. Writing the data register stores a 16-bit value into that PHY register. Setting the read-request bit in the command register copies the selected PHY register into a result register, which the next bus read returns.

The model answers only at one fixed PHY address. A read at any other address gives all ones, and a write to any other address is dropped. A soft reset written to the PHY control register takes effect at once. The same holds for auto-negotiation enable. Both bits then read back as zero. The auto-negotiation-done and link-up bits of the PHY status register follow a synchronous link input. Serial management bit timing is not modelled.

Top module: `mgmt_phy_model`

## Requirements
- R1: Byte offsets are 0x24 for command, 0x28 for target, 0x2C for data and 0x30 for result. Access is by whole 32-bit words, and an access whose two low address bits are not zero reaches no register. The target register reads back its register number in bits [4:0] and its PHY address in bits [12:8], with every other bit zero. The data register reads back all 32 written bits. The command register and unmapped offsets read as zero. Read data appears on `bus_rdata` one clock after `bus_rd_en` and holds until the next read.
- R2: After reset the target, data and result registers read zero. The PHY registers hold these values: control (0) 0x1140, status (1) 0x7948 (link seen as down), identifier high (2) 0x0022, identifier low (3) 0x1550, advertisement (4) 0x01E1, partner ability (5) 0xCDE1. Every other PHY register holds zero.
- R3: A command write with bit 0 set loads the selected PHY register into the result register in that clock, so a read one cycle later returns it. A command write with bit 0 clear leaves the result register unchanged.
- R4: A read request whose target PHY address is not the responding address (parameter, default 1) loads 0xFFFF into the result register.
- R5: A data write at the responding address stores data bits [15:0] into the selected PHY register. Any of the 32 registers can be written, including status and identifiers.
- R6: A data write to any other PHY address leaves every PHY register unchanged.
- R7: A control write with bit 15 set reloads all R2 values, with status bits 5 and 2 following the current link level. The control register then holds the written value with bit 15 cleared.
- R8: A control write with bit 12 set sets status bit 5. The control register holds the written value with bit 12 cleared.
- R9: One clock after the link input changes, status bits 5 and 2 both equal the new link level. No other status bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| link_in | input | 1 | Link level, synchronous to clk |

## Verification
The checker watches every cycle. It checks that a read request loads either the selected register or all ones. It checks that foreign-address writes leave control and status untouched, and that the written control register never keeps its self-clearing bits. It also checks that auto-negotiation sets the done bit, that status bits 5 and 2 follow each link edge, and that read data holds between reads. Some behaviour shows only through the bench's scripted sequences. This covers the full default image, the restoration of written registers by soft reset, and the readback format of the target and data registers. It also covers misaligned accesses and status bits that stay put while the link toggles.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int REG_IDX_W  = 5;
  localparam int PHY_ADDR_W = 5;
  localparam int NUM_REGS   = 2 ** REG_IDX_W;

  localparam int OFS_CMD    = 'h24;
  localparam int OFS_TARGET = 'h28;
  localparam int OFS_DATA   = 'h2C;
  localparam int OFS_RESULT = 'h30;

  localparam int IDX_CTRL    = 0;
  localparam int IDX_STAT    = 1;
  localparam int IDX_ID_HI   = 2;
  localparam int IDX_ID_LO   = 3;
  localparam int IDX_ADV     = 4;
  localparam int IDX_PARTNER = 5;

  localparam int CTRL_SOFT_RST = 15;
  localparam int CTRL_AN_EN    = 12;
  localparam int STAT_AN_DONE  = 5;
  localparam int STAT_LINK     = 2;

  typedef logic [15:0] phy_word_t;

  typedef struct packed {
    logic [PHY_ADDR_W-1:0] phy_addr;
    logic [REG_IDX_W-1:0]  reg_idx;
  } mgmt_target_t;

  function automatic phy_word_t phy_default(input int idx);
    case (idx)
      IDX_CTRL:    return 16'h1140;
      IDX_STAT:    return 16'h7968;
      IDX_ID_HI:   return 16'h0022;
      IDX_ID_LO:   return 16'h1550;
      IDX_ADV:     return 16'h01E1;
      IDX_PARTNER: return 16'hCDE1;
      default:     return 16'h0000;
    endcase
  endfunction

  function automatic phy_word_t with_link(input phy_word_t w, input logic up);
    phy_word_t r;
    r = w;
    r[STAT_AN_DONE] = up;
    r[STAT_LINK]    = up;
    return r;
  endfunction
endpackage

// File: rtl/mgmt_bus_front.sv
module mgmt_bus_front
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PHY_ID = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  phy_word_t            phy_rd_data,
  output logic [31:0]          bus_rdata,
  output logic [REG_IDX_W-1:0] tgt_reg,
  output logic                 phy_sel_ok,
  output logic                 data_wr_hit,
  output logic                 rd_capture,
  output phy_word_t            phy_wr_data,
  output phy_word_t            result_q
);
  localparam int WORD_W = ADDR_W - 2;

  mgmt_target_t tgt_q, tgt_d;
  logic [31:0]  data_q, data_d;
  phy_word_t    result_d;
  logic [31:0]  rdata_q, rdata_d;
  logic         aligned;
  logic [WORD_W-1:0] word;
  logic         cmd_hit, tgt_hit;
  logic         tgt_en, data_en, result_en, rdata_en;

  always_comb begin
    aligned     = (bus_addr[1:0] == 2'b00);
    word        = bus_addr[ADDR_W-1:2];
    cmd_hit     = bus_wr_en && aligned && (word == WORD_W'(OFS_CMD >> 2));
    tgt_hit     = bus_wr_en && aligned && (word == WORD_W'(OFS_TARGET >> 2));
    data_wr_hit = bus_wr_en && aligned && (word == WORD_W'(OFS_DATA >> 2));
    rd_capture  = cmd_hit && bus_wdata[0];

    phy_sel_ok  = (tgt_q.phy_addr == PHY_ADDR_W'(PHY_ID));
    tgt_reg     = tgt_q.reg_idx;
    phy_wr_data = bus_wdata[15:0];

    tgt_d.reg_idx  = bus_wdata[REG_IDX_W-1:0];
    tgt_d.phy_addr = bus_wdata[8 +: PHY_ADDR_W];
    tgt_en         = tgt_hit;

    data_d  = bus_wdata;
    data_en = data_wr_hit;

    result_d  = phy_sel_ok ? phy_rd_data : 16'hFFFF;
    result_en = rd_capture;

    rdata_d = 32'h0;
    if (aligned) begin
      case (word)
        WORD_W'(OFS_TARGET >> 2): rdata_d = {19'h0, tgt_q.phy_addr, 3'b000, tgt_q.reg_idx};
        WORD_W'(OFS_DATA >> 2):   rdata_d = data_q;
        WORD_W'(OFS_RESULT >> 2): rdata_d = {16'h0, result_q};
        default:                  rdata_d = 32'h0;
      endcase
    end
    rdata_en = bus_rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q    <= '0;
      data_q   <= '0;
      result_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (tgt_en)    tgt_q    <= tgt_d;
      if (data_en)   data_q   <= data_d;
      if (result_en) result_q <= result_d;
      if (rdata_en)  rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/phy_link_tracker.sv
module phy_link_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic link_chg
);
  logic link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_in;
  end

  assign link_chg = link_in ^ link_q;
endmodule

// File: rtl/phy_reg_model.sv
module phy_reg_model
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  phy_word_t            wr_data,
  input  logic [REG_IDX_W-1:0] rd_idx,
  input  logic                 link_in,
  input  logic                 link_chg,
  output phy_word_t            rd_data,
  output phy_word_t            ctl_q,
  output phy_word_t            sts_q
);
  phy_word_t regs_q [NUM_REGS];
  phy_word_t regs_d [NUM_REGS];
  phy_word_t wr_word;
  logic      upd_en;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
    wr_word = wr_data;
    if (wr_req) begin
      if (wr_idx == REG_IDX_W'(IDX_CTRL)) begin
        if (wr_word[CTRL_SOFT_RST]) begin
          for (int i = 0; i < NUM_REGS; i++) regs_d[i] = phy_default(i);
          regs_d[IDX_STAT] = with_link(phy_default(IDX_STAT), link_in);
          wr_word[CTRL_SOFT_RST] = 1'b0;
        end
        if (wr_word[CTRL_AN_EN]) begin
          regs_d[IDX_STAT][STAT_AN_DONE] = 1'b1;
          wr_word[CTRL_AN_EN] = 1'b0;
        end
      end
      regs_d[wr_idx] = wr_word;
    end
    if (link_chg) regs_d[IDX_STAT] = with_link(regs_d[IDX_STAT], link_in);
    upd_en = wr_req | link_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (i == IDX_STAT) regs_q[i] <= with_link(phy_default(i), 1'b0);
        else               regs_q[i] <= phy_default(i);
      end
    end else if (upd_en) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign rd_data = regs_q[rd_idx];
  assign ctl_q   = regs_q[IDX_CTRL];
  assign sts_q   = regs_q[IDX_STAT];
endmodule

// File: rtl/mgmt_phy_model.sv
module mgmt_phy_model
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PHY_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              link_in
);
  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  logic [REG_IDX_W-1:0] tgt_reg;
  logic                 phy_sel_ok, data_wr_hit, rd_capture, link_chg;
  phy_word_t            phy_wr_data, phy_rd_data, result_q, ctl_q, sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mgmt_bus_front #(.ADDR_W(ADDR_W), .PHY_ID(PHY_ID)) u_front (
    .clk(clk), .rst_n(rst_int_n),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .phy_rd_data(phy_rd_data), .bus_rdata(bus_rdata),
    .tgt_reg(tgt_reg), .phy_sel_ok(phy_sel_ok),
    .data_wr_hit(data_wr_hit), .rd_capture(rd_capture),
    .phy_wr_data(phy_wr_data), .result_q(result_q)
  );

  phy_link_tracker u_link (
    .clk(clk), .rst_n(rst_int_n), .link_in(link_in), .link_chg(link_chg)
  );

  phy_reg_model u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr_req(data_wr_hit && phy_sel_ok), .wr_idx(tgt_reg),
    .wr_data(phy_wr_data), .rd_idx(tgt_reg),
    .link_in(link_in), .link_chg(link_chg),
    .rd_data(phy_rd_data), .ctl_q(ctl_q), .sts_q(sts_q)
  );
endmodule

// File: rtl/mgmt_phy_model_chk.sv
module mgmt_phy_model_chk
  import mdio_mgmt_pkg::*;
(
  input logic                 clk,
  input logic                 rst_int_n,
  input logic                 bus_rd_en,
  input logic [31:0]          bus_rdata,
  input logic                 link_in,
  input logic                 link_chg,
  input logic                 rd_capture,
  input logic                 data_wr_hit,
  input logic                 phy_sel_ok,
  input logic [REG_IDX_W-1:0] tgt_reg,
  input phy_word_t            phy_wr_data,
  input phy_word_t            phy_rd_data,
  input phy_word_t            result_q,
  input phy_word_t            ctl_q,
  input phy_word_t            sts_q
);
  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd_en |=> $stable(bus_rdata));

  // R3
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_capture && phy_sel_ok |=> result_q == $past(phy_rd_data));

  // R4
  foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_capture && !phy_sel_ok |=> result_q == 16'hFFFF);

  // R6
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_wr_hit && !phy_sel_ok && !link_chg |=> $stable(ctl_q) && $stable(sts_q));

  // R7
  ctl_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_wr_hit && phy_sel_ok && tgt_reg == REG_IDX_W'(IDX_CTRL)
    |=> !ctl_q[CTRL_SOFT_RST] && !ctl_q[CTRL_AN_EN]);

  // R8
  an_done_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_wr_hit && phy_sel_ok && tgt_reg == REG_IDX_W'(IDX_CTRL)
    && phy_wr_data[CTRL_AN_EN] && !link_chg |=> sts_q[STAT_AN_DONE]);

  // R9
  link_track_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    link_chg |=> sts_q[STAT_AN_DONE] == $past(link_in) && sts_q[STAT_LINK] == $past(link_in));
endmodule

bind mgmt_phy_model mgmt_phy_model_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
  .link_in(link_in), .link_chg(link_chg), .rd_capture(rd_capture),
  .data_wr_hit(data_wr_hit), .phy_sel_ok(phy_sel_ok), .tgt_reg(tgt_reg),
  .phy_wr_data(phy_wr_data), .phy_rd_data(phy_rd_data), .result_q(result_q),
  .ctl_q(ctl_q), .sts_q(sts_q)
);

// File: tb/mgmt_phy_model_test.sv
module mgmt_phy_model_test;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_CMD = 8'h24, A_TGT = 8'h28, A_DATA = 8'h2C, A_RES = 8'h30;

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, link;
  logic [ADDR_W-1:0] addr;
  logic [31:0] wdata, rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  mgmt_phy_model #(.ADDR_W(ADDR_W), .PHY_ID(1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .link_in(link)
  );

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL unexpected read data actual=%h expected=none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fails++;
          $display("FAIL %s actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic mii_read(input int phy, input int r, input logic [15:0] e, input string t);
    bus_write(A_TGT, (32'(phy) << 8) | 32'(r));
    bus_write(A_CMD, 32'h1);
    bus_read(A_RES, {16'h0, e}, t);
  endtask

  task automatic mii_write(input int phy, input int r, input logic [31:0] d);
    bus_write(A_TGT, (32'(phy) << 8) | 32'(r));
    bus_write(A_DATA, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; link = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 front register reset state, R1 command reads zero
    bus_read(A_TGT, 32'h0, "R2 target reset");
    bus_read(A_DATA, 32'h0, "R2 data reset");
    bus_read(A_RES, 32'h0, "R2 result reset");
    bus_read(A_CMD, 32'h0, "R1 command reads zero");

    // R2 PHY default image, link down
    mii_read(1, 0, 16'h1140, "R2 ctrl default");
    mii_read(1, 1, 16'h7948, "R2 status default");
    mii_read(1, 2, 16'h0022, "R2 id hi default");
    mii_read(1, 3, 16'h1550, "R2 id lo default");
    mii_read(1, 4, 16'h01E1, "R2 adv default");
    mii_read(1, 5, 16'hCDE1, "R2 partner default");
    mii_read(1, 7, 16'h0000, "R2 reg7 default");
    mii_read(1, 31, 16'h0000, "R2 reg31 default");

    // R9 link tracking
    link = 1'b1; @(negedge clk);
    mii_read(1, 1, 16'h796C, "R9 link up");
    link = 1'b0; @(negedge clk);
    mii_read(1, 1, 16'h7948, "R9 link down");

    // R4 foreign reads, R3 command without bit 0
    mii_read(2, 0, 16'hFFFF, "R4 phy2 read");
    mii_read(1, 2, 16'h0022, "R3 capture");
    mii_read(0, 2, 16'hFFFF, "R4 phy0 read");
    bus_write(A_CMD, 32'h0);
    bus_read(A_RES, 32'h0000FFFF, "R3 no capture without bit0");

    // R5 writes at responding address
    mii_write(1, 7, 32'h0000A5A5);
    mii_read(1, 7, 16'hA5A5, "R5 reg7 write");
    mii_write(1, 8, 32'hDEAD1234);
    mii_read(1, 8, 16'h1234, "R5 low half stored");
    bus_read(A_DATA, 32'hDEAD1234, "R1 data readback");

    // R6 foreign write ignored
    mii_write(3, 7, 32'h00001111);
    mii_read(1, 7, 16'hA5A5, "R6 foreign write ignored");

    // R1 target readback and misaligned access
    bus_write(A_TGT, 32'hFFFFFFFF);
    bus_read(A_TGT, 32'h00001F1F, "R1 target fields");
    bus_write(8'h29, 32'h00000005);
    bus_read(A_TGT, 32'h00001F1F, "R1 misaligned ignored");
    bus_read(8'h2E, 32'h0, "R1 misaligned read zero");

    // R8 auto-negotiation
    mii_write(1, 1, 32'h0);
    mii_read(1, 1, 16'h0000, "R5 status writable");
    mii_write(1, 0, 32'h00001000);
    mii_read(1, 0, 16'h0000, "R8 an bit self clears");
    mii_read(1, 1, 16'h0020, "R8 an done set");

    // R7 soft reset
    link = 1'b1; @(negedge clk);
    mii_read(1, 1, 16'h0024, "R9 link up on written status");
    mii_write(1, 0, 32'h00008000);
    mii_read(1, 0, 16'h0000, "R7 reset bit self clears");
    mii_read(1, 1, 16'h796C, "R7 status reload link up");
    mii_read(1, 7, 16'h0000, "R7 reg7 restored");
    mii_read(1, 8, 16'h0000, "R7 reg8 restored");
    mii_read(1, 4, 16'h01E1, "R7 adv restored");
    mii_write(1, 0, 32'h00009100);
    mii_read(1, 0, 16'h0100, "R7 R8 combined ctrl");
    mii_read(1, 1, 16'h796C, "R7 R8 combined status");
    link = 1'b0; @(negedge clk);
    mii_write(1, 0, 32'h00009000);
    mii_read(1, 0, 16'h0000, "R7 R8 ctrl link down");
    mii_read(1, 1, 16'h7968, "R8 an done after reset link down");

    // R9 only bits 5 and 2 move
    mii_write(1, 1, 32'h0000FFFF);
    mii_read(1, 1, 16'hFFFF, "R5 status all ones");
    link = 1'b1; @(negedge clk);
    mii_read(1, 1, 16'hFFFF, "R9 link up keeps others");
    link = 1'b0; @(negedge clk);
    mii_read(1, 1, 16'hFFDB, "R9 link down clears two bits");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fails++;
      $display("FAIL R1 missing read data actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule